// File: doc/BRIEF.md
# ADC Queue Scan Status Controller

This block walks one conversion queue through a short list of command words. Each word names an input channel and carries two control bits: one that asks for a pause after the word, and one that marks the end of the queue. For every word the block raises a conversion request with the channel number. It moves on when a done handshake reports that the result has been stored. Scans are started by software, by an external trigger pulse, or by an external gate level, depending on the scan mode.

The block keeps three sticky status flags: pause reached, queue complete, and trigger overrun. An interrupt request is raised when any flag is set together with its enable. Software reaches the command list, the control word and the status word through a small register port. A status flag clears only when software writes zero to it after it was last read as one. Converter timing, result storage and interrupt level routing are outside the block.

Top module: `adc_qscan_ctrl`

## Requirements
- R1: After reset, all flags are 0, the state is idle (status bits [5:4] = 0), the pointer is 0, conv_req_o is 0, irq_o is 0, and the control word reads 0.
- R2: A scan requests conversions in word order starting at word 0, with conv_chan_o taken from bits [5:0] of the current word. It advances on each conv_done_i and ends after the word whose end bit (bit 7) is set, or after the last array slot.
- R3: In the trigger and gated modes, a finished word whose pause bit (bit 6) is set sets the pause flag (status bit 0) and enters the paused state (status [5:4] = 2) with the pointer on the next word. No request is made until the next trigger event, which resumes at that word.
- R4: If a word has both the pause bit and the end bit set, the queue goes idle instead of paused, and both the pause flag and the completion flag (status bit 1) are set.
- R5: In the software modes (mode 1 single, mode 2 continuous), a pause word sets the pause flag but the scan continues. trig_i is ignored. Software continuous mode restarts at word 0 after the end word.
- R6: In the trigger modes (mode 3 single, mode 4 continuous), a trig_i pulse while the queue is active sets the overrun flag (status bit 2). The pulse is not stored and does not change the conversion order.
- R7: The overrun flag is never set in software modes.
- R8: In gated mode (mode 5), the queue runs while gate_i is high, restarts at word 0 after each end word, and goes idle when gate_i falls. Overrun is set when a second end word is reached within one open gate while the completion flag is still set. An end word in a new gate window never counts the previous window.
- R9: A write of 0 to a status bit clears it only if that bit read as 1 since the last status write. Any status write cancels all read-as-one marks, and a written 1 has no effect. A hardware set in the same cycle as a clear wins.
- R10: irq_o is high when any flag is set and its enable is set (control bits 4 pause, 5 completion, 6 overrun). Flags update whether or not the enables are set.
- R11: Register map: addresses 0..DEPTH-1 are the command words (read back as written). Address DEPTH is the control word: mode [2:0], enables [6:4], and a write-only start bit 8. Address DEPTH+1 is the status word: flags [2:0], state [5:4], pointer [11:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | $clog2(DEPTH)+1 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| trig_i | input | 1 | Trigger event pulse (external edge or interval timer) |
| gate_i | input | 1 | External gate level |
| conv_req_o | output | 1 | Conversion request for the current word |
| conv_chan_o | output | CHAN_W | Channel of the current word |
| conv_done_i | input | 1 | Result stored, one-cycle pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The scoreboard holds the channel order expected from each scan. It is driven with a software single scan over a queue that contains a pause word, and with triggered scans that pause partway through and stop on a pause-plus-end word. It is also driven with three gate windows and with a software continuous loop. Comparing these runs separates a pause that stops the queue from one that only sets the flag. It also separates an end word that idles the queue from one that restarts it. Extra trigger pulses, sent during idle and during an active software scan, show that those pulses neither start nor disturb a scan. Gate windows with one pass and with two passes show that overrun counts end words only within the current window. Clearing is tried with writes that are not preceded by a read and with partial masks.

// File: rtl/adc_qscan_pkg.sv
package adc_qscan_pkg;

  typedef enum logic [2:0] {
    MODE_OFF         = 3'd0,
    MODE_SW_SINGLE   = 3'd1,
    MODE_SW_CONT     = 3'd2,
    MODE_TRIG_SINGLE = 3'd3,
    MODE_TRIG_CONT   = 3'd4,
    MODE_GATED       = 3'd5
  } scan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_PAUSED = 2'd2
  } q_state_e;

  localparam int FLAG_PAUSE = 0;
  localparam int FLAG_COMP  = 1;
  localparam int FLAG_TOR   = 2;
  localparam int NUM_FLAGS  = 3;

  function automatic logic is_sw_mode(scan_mode_e m);
    return (m == MODE_SW_SINGLE) || (m == MODE_SW_CONT);
  endfunction

  function automatic logic is_trig_mode(scan_mode_e m);
    return (m == MODE_TRIG_SINGLE) || (m == MODE_TRIG_CONT);
  endfunction

endpackage

// File: rtl/qscan_cmd_mem.sv
module qscan_cmd_mem #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_a_i,
  output logic [WORD_W-1:0] rdata_a_o,
  input  logic [PTR_W-1:0]  raddr_b_i,
  output logic [WORD_W-1:0] rdata_b_o
);

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

endmodule

// File: rtl/qscan_flags.sv
module qscan_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flag_o
);

  logic [N-1:0] flag_q, rd1_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[g] <= 1'b0;
        rd1_q[g]  <= 1'b0;
      end else begin
        // set beats a simultaneous clear
        if (set_i[g])                              flag_q[g] <= 1'b1;
        else if (wr_i && !wdata_i[g] && rd1_q[g])  flag_q[g] <= 1'b0;
        if (wr_i)      rd1_q[g] <= 1'b0;
        else if (rd_i) rd1_q[g] <= flag_q[g];
      end
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/qscan_seq.sv
module qscan_seq
  import adc_qscan_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  scan_mode_e           mode_i,
  input  logic                 sw_start_i,
  input  logic                 trig_i,
  input  logic                 gate_i,
  input  logic                 cmd_pause_i,
  input  logic                 cmd_eoq_i,
  input  logic                 conv_done_i,
  input  logic                 comp_flag_i,
  output logic [PTR_W-1:0]     ptr_o,
  output q_state_e             state_o,
  output logic                 conv_req_o,
  output logic [NUM_FLAGS-1:0] set_o
);

  q_state_e         st_q, st_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             eoq_seen_q, eoq_seen_d;

  logic sw_m, trig_m, gated_m, run_m, start_ev, last_w;

  assign sw_m    = is_sw_mode(mode_i);
  assign trig_m  = is_trig_mode(mode_i);
  assign gated_m = (mode_i == MODE_GATED);
  assign run_m   = sw_m || trig_m || gated_m;
  assign start_ev = (sw_m && sw_start_i) || (trig_m && trig_i) || (gated_m && gate_i);
  assign last_w  = cmd_eoq_i || (ptr_q == PTR_W'(DEPTH - 1));

  always_comb begin
    st_d       = st_q;
    ptr_d      = ptr_q;
    eoq_seen_d = (gated_m && gate_i) ? eoq_seen_q : 1'b0;
    set_o      = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_ev) begin
          st_d  = ST_ACTIVE;
          ptr_d = '0;
        end
      end
      ST_PAUSED: begin
        if (!run_m) begin
          st_d  = ST_IDLE;
          ptr_d = '0;
        end else if (start_ev) begin
          st_d = ST_ACTIVE;
        end
      end
      ST_ACTIVE: begin
        if (!run_m || (gated_m && !gate_i)) begin
          st_d  = ST_IDLE;
          ptr_d = '0;
        end else begin
          if (trig_m && trig_i) set_o[FLAG_TOR] = 1'b1;
          if (conv_done_i) begin
            if (last_w) begin
              set_o[FLAG_COMP] = 1'b1;
              if (cmd_pause_i) set_o[FLAG_PAUSE] = 1'b1;
              ptr_d = '0;
              if (gated_m) begin
                if (eoq_seen_q && comp_flag_i) set_o[FLAG_TOR] = 1'b1;
                eoq_seen_d = 1'b1;
              end else if (mode_i != MODE_SW_CONT) begin
                st_d = ST_IDLE;
              end
            end else begin
              ptr_d = ptr_q + 1'b1;
              if (cmd_pause_i) begin
                set_o[FLAG_PAUSE] = 1'b1;
                if (!sw_m) st_d = ST_PAUSED;
              end
            end
          end
        end
      end
      default: begin
        st_d  = ST_IDLE;
        ptr_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ptr_q      <= '0;
      eoq_seen_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      ptr_q      <= ptr_d;
      eoq_seen_q <= eoq_seen_d;
    end
  end

  assign ptr_o      = ptr_q;
  assign state_o    = st_q;
  assign conv_req_o = (st_q == ST_ACTIVE);

endmodule

// File: rtl/adc_qscan_ctrl.sv
module adc_qscan_ctrl
  import adc_qscan_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int CHAN_W = 6,
  parameter int DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic                     reg_re_i,
  input  logic [$clog2(DEPTH):0]   reg_addr_i,
  input  logic [DATA_W-1:0]        reg_wdata_i,
  output logic [DATA_W-1:0]        reg_rdata_o,
  input  logic                     trig_i,
  input  logic                     gate_i,
  output logic                     conv_req_o,
  output logic [CHAN_W-1:0]        conv_chan_o,
  input  logic                     conv_done_i,
  output logic                     irq_o
);

  localparam int PTR_W    = $clog2(DEPTH);
  localparam int ADDR_W   = PTR_W + 1;
  localparam int CMD_W    = CHAN_W + 2;
  localparam int PAUSE_B  = CHAN_W;
  localparam int EOQ_B    = CHAN_W + 1;
  localparam int IE_LSB   = 4;
  localparam int START_B  = 8;
  localparam int ST_LSB   = 4;
  localparam int PTR_LSB  = 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(DEPTH + 1);

  logic is_cmd, is_ctrl, is_stat;
  assign is_cmd  = !reg_addr_i[PTR_W];
  assign is_ctrl = (reg_addr_i == CTRL_ADDR);
  assign is_stat = (reg_addr_i == STAT_ADDR);

  logic status_wr, status_rd;
  assign status_wr = reg_we_i && is_stat;
  assign status_rd = reg_re_i && is_stat;

  // control word; start is delayed so it sees a mode written with it
  scan_mode_e           mode_q;
  logic [NUM_FLAGS-1:0] ie_q;
  logic                 start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OFF;
      ie_q    <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= reg_we_i && is_ctrl && reg_wdata_i[START_B];
      if (reg_we_i && is_ctrl) begin
        mode_q <= scan_mode_e'(reg_wdata_i[2:0]);
        ie_q   <= reg_wdata_i[IE_LSB +: NUM_FLAGS];
      end
    end
  end

  logic [PTR_W-1:0] ptr;
  logic [CMD_W-1:0] cur_cmd, rd_cmd;

  qscan_cmd_mem #(.DEPTH(DEPTH), .WORD_W(CMD_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i && is_cmd),
    .waddr_i   (reg_addr_i[PTR_W-1:0]),
    .wdata_i   (reg_wdata_i[CMD_W-1:0]),
    .raddr_a_i (ptr),
    .rdata_a_o (cur_cmd),
    .raddr_b_i (reg_addr_i[PTR_W-1:0]),
    .rdata_b_o (rd_cmd)
  );

  q_state_e             st;
  logic [NUM_FLAGS-1:0] flag_set, flags;

  qscan_seq #(.DEPTH(DEPTH)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_q),
    .sw_start_i  (start_q),
    .trig_i      (trig_i),
    .gate_i      (gate_i),
    .cmd_pause_i (cur_cmd[PAUSE_B]),
    .cmd_eoq_i   (cur_cmd[EOQ_B]),
    .conv_done_i (conv_done_i),
    .comp_flag_i (flags[FLAG_COMP]),
    .ptr_o       (ptr),
    .state_o     (st),
    .conv_req_o  (conv_req_o),
    .set_o       (flag_set)
  );

  qscan_flags #(.N(NUM_FLAGS)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .rd_i    (status_rd),
    .wr_i    (status_wr),
    .wdata_i (reg_wdata_i[NUM_FLAGS-1:0]),
    .flag_o  (flags)
  );

  assign conv_chan_o = cur_cmd[CHAN_W-1:0];
  assign irq_o       = |(flags & ie_q);

  always_comb begin
    reg_rdata_o = '0;
    if (is_cmd) begin
      reg_rdata_o[CMD_W-1:0] = rd_cmd;
    end else if (is_ctrl) begin
      reg_rdata_o[2:0]                   = mode_q;
      reg_rdata_o[IE_LSB +: NUM_FLAGS]   = ie_q;
    end else if (is_stat) begin
      reg_rdata_o[NUM_FLAGS-1:0]         = flags;
      reg_rdata_o[ST_LSB +: 2]           = st;
      reg_rdata_o[PTR_LSB +: PTR_W]      = ptr;
    end
  end

endmodule

// File: rtl/adc_qscan_ctrl_chk.sv
module adc_qscan_ctrl_chk #(
  parameter int CHAN_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        mode_i,
  input logic [1:0]        st_i,
  input logic [2:0]        flags_i,
  input logic              status_wr_i,
  input logic              reg_we_i,
  input logic              conv_req_i,
  input logic              conv_done_i,
  input logic [CHAN_W-1:0] conv_chan_i
);

  // flags fall only after a status write (R9)
  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(flags_i) & ~flags_i)) |-> $past(status_wr_i));

  // no overrun decided under a software mode (R7)
  assert_no_tor_sw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[2]) |-> !(($past(mode_i) == 3'd1) || ($past(mode_i) == 3'd2)));

  // paused state never entered from a software mode (R5)
  assert_sw_no_pause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_i == 2'd2) |-> !(($past(mode_i) == 3'd1) || ($past(mode_i) == 3'd2)));

  // entering pause always comes with the pause flag (R3)
  assert_pause_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_i == 2'd2) |-> flags_i[0]);

  // request channel holds until the word is done (R2)
  assert_chan_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_i && !conv_done_i && !reg_we_i) |=> (!conv_req_i || $stable(conv_chan_i)));

endmodule

bind adc_qscan_ctrl adc_qscan_ctrl_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_q),
  .st_i        (st),
  .flags_i     (flags),
  .status_wr_i (status_wr),
  .reg_we_i    (reg_we_i),
  .conv_req_i  (conv_req_o),
  .conv_done_i (conv_done_i),
  .conv_chan_i (conv_chan_o)
);

// File: tb/adc_qscan_ctrl_tb.sv
module adc_qscan_ctrl_tb;

  localparam logic [4:0] CTRL = 5'd16;
  localparam logic [4:0] STAT = 5'd17;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        trig_i = 1'b0, gate_i = 1'b0;
  logic        conv_req_o;
  logic [5:0]  conv_chan_o;
  logic        conv_done_i = 1'b0;
  logic        irq_o;

  int tests = 0, fails = 0;
  logic [5:0] exp_q[$];
  logic [15:0] rv;

  always #5 clk_i = ~clk_i;

  adc_qscan_ctrl u_dut (
    .clk_i, .rst_ni, .reg_we_i, .reg_re_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .trig_i, .gate_i, .conv_req_o, .conv_chan_o, .conv_done_i, .irq_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk_i);
    reg_re_i = 1'b1; reg_addr_i = a;
    #1 d = reg_rdata_o;
    @(negedge clk_i);
    reg_re_i = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk_i); trig_i = 1'b1;
    @(negedge clk_i); trig_i = 1'b0;
  endtask

  task automatic push(input logic [5:0] ch);
    exp_q.push_back(ch);
  endtask

  // responder + scoreboard monitor: done two cycles into each request
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk_i);
      if (conv_done_i) begin
        conv_done_i = 1'b0;
        cnt = 0;
      end else if (conv_req_o) begin
        cnt++;
        if (cnt >= 2) begin
          conv_done_i = 1'b1;
          tests++;
          if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R2: actual conversion ch %0d expected none", conv_chan_o);
          end else begin
            logic [5:0] e;
            e = exp_q.pop_front();
            if (conv_chan_o !== e) begin
              fails++;
              $display("FAIL R2: actual ch %0d expected ch %0d", conv_chan_o, e);
            end
          end
        end
      end else begin
        cnt = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(STAT, rv); check("R1 status", rv, 16'h0000);
    rd(CTRL, rv); check("R1 ctrl", rv, 16'h0000);
    check("R1 req", conv_req_o, 0);
    check("R1 irq", irq_o, 0);

    // R11 command word readback
    wr(0, 16'h0005); wr(1, 16'h0049); wr(2, 16'h000C); wr(3, 16'h0094);
    rd(1, rv); check("R11 cmd readback", rv, 16'h0049);

    // R2 R5 software single scan passes a pause word
    push(5); push(9); push(12); push(20);
    wr(CTRL, 16'h0101);
    rd(CTRL, rv); check("R11 ctrl readback", rv, 16'h0001);
    repeat (30) @(negedge clk_i);
    check("R2 queue drained", exp_q.size(), 0);
    rd(STAT, rv); check("R5 sw pause continues", rv, 16'h0003);

    // R9 clear rules
    wr(STAT, 16'h0007);
    wr(STAT, 16'h0000);
    rd(STAT, rv); check("R9 zero without read", rv, 16'h0003);
    wr(STAT, 16'h0002);
    rd(STAT, rv); check("R9 partial clear", rv, 16'h0002);
    wr(STAT, 16'h0000);
    rd(STAT, rv); check("R9 full clear", rv, 16'h0000);

    // R5 R7 trigger ignored in software mode
    wr(CTRL, 16'h0001);
    pulse_trig();
    repeat (5) @(negedge clk_i);
    check("R5 trig no start", conv_req_o, 0);
    push(5); push(9); push(12); push(20);
    wr(CTRL, 16'h0101);
    pulse_trig(); pulse_trig();
    repeat (30) @(negedge clk_i);
    check("R2 sw rerun drained", exp_q.size(), 0);
    rd(STAT, rv); check("R7 no overrun sw", rv, 16'h0003);
    wr(STAT, 16'h0000);

    // R3 R6 triggered single scan with pause and overrun
    wr(0, 16'h0041); wr(1, 16'h0002); wr(2, 16'h0083);
    wr(CTRL, 16'h0003);
    push(1);
    pulse_trig();
    repeat (20) @(negedge clk_i);
    check("R3 paused no req", conv_req_o, 0);
    rd(STAT, rv); check("R3 paused status", rv, 16'h0121);
    wr(STAT, 16'h0000);
    push(2); push(3);
    pulse_trig(); pulse_trig();
    repeat (20) @(negedge clk_i);
    check("R6 order kept", exp_q.size(), 0);
    rd(STAT, rv); check("R6 overrun set", rv, 16'h0006);
    wr(STAT, 16'h0000);

    // R4 R10 pause on last word, interrupt
    wr(0, 16'h0007); wr(1, 16'h00C8);
    wr(CTRL, 16'h0023);
    push(7); push(8);
    pulse_trig();
    repeat (20) @(negedge clk_i);
    check("R10 irq on comp", irq_o, 1);
    rd(STAT, rv); check("R4 idle both flags", rv, 16'h0003);
    wr(CTRL, 16'h0003);
    check("R10 irq masked", irq_o, 0);
    rd(STAT, rv); check("R10 flags kept", rv, 16'h0003);
    wr(STAT, 16'h0000);

    // R8 gated windows
    wr(0, 16'h0004); wr(1, 16'h0086);
    wr(CTRL, 16'h0005);
    push(4); push(6);
    @(negedge clk_i); gate_i = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk_i); gate_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rd(STAT, rv); check("R8 one pass", rv, 16'h0002);
    push(4); push(6);
    @(negedge clk_i); gate_i = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk_i); gate_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rd(STAT, rv); check("R8 new window no overrun", rv, 16'h0002);
    push(4); push(6); push(4); push(6);
    @(negedge clk_i); gate_i = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk_i); gate_i = 1'b0;
    repeat (5) @(negedge clk_i);
    check("R8 gate closed idle", conv_req_o, 0);
    rd(STAT, rv); check("R8 two passes overrun", rv, 16'h0006);
    wr(STAT, 16'h0000);

    // R5 software continuous loops
    push(4); push(6); push(4); push(6);
    wr(CTRL, 16'h0102);
    wait (exp_q.size() == 0);
    wr(CTRL, 16'h0000);
    repeat (5) @(negedge clk_i);
    check("R5 cont stopped", conv_req_o, 0);
    rd(STAT, rv); check("R5 cont status", rv, 16'h0002);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule